// File: doc/BRIEF.md
# Vectored Interrupt Controller with Halt Wake

The block gathers five interrupt request lines into a flag register and qualifies them with an enable register. A CPU core reads and writes both registers. When the master enable input is set and an enabled request is pending, the block selects the pending request with the lowest index. It then pulses a start signal that tells the core to drop its master enable. A five-cycle dispatch window follows. During the window the core pushes its program counter. On the fifth cycle the block presents the vector address and clears the serviced flag bit.

The serviced bit is cleared by flipping it, not by forcing it to zero. If software clears that bit by hand during the window, the flip sets it again. A separate wake output releases a halted core whenever an enabled request is pending. This output does not depend on the master enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A high bit on `irq_req` in a cycle sets the matching flag bit at the next clock edge. Flag bits that are already set stay set.
- R2: The vector address is 0x40 + 8 × index of the serviced interrupt. Index 0 gives 0x40 and index 4 gives 0x60.
- R3: At the end of the fifth window cycle, the serviced flag bit is XORed with a one-hot mask of its index. A bit that software cleared earlier in the window therefore reads 1 afterwards.
- R4: `wake` is 1 when `halt_in` is 1 and (enable AND flag) is nonzero, whatever the value of `ime`.
- R5: `disp_start` is 1 only when `ime` is 1, no window is running, and (enable AND flag) is nonzero. This pulse tells the core to clear its master enable.
- R6: After `disp_start`, `disp_busy` is 1 for exactly five cycles. `vec_load` is 1 only in the fifth of those cycles.
- R7: When several enabled requests are pending, the lowest index is serviced.
- R8: The flag register reads with bits 7:5 set to 1. The enable register reads with bits 7:5 set to 0. Only bits 4:0 of each register are stored.
- R9: A write to the flag register (`reg_sel`=0) in the same cycle as a request takes precedence, so the written value is loaded.
- R10: No new `disp_start` occurs while a window is running, even if `ime` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 5 | Request pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| reg_wdata | input | 8 | Write data |
| flag_rdata | output | 8 | Flag register read value |
| en_rdata | output | 8 | Enable register read value |
| ime | input | 1 | Master enable from the core |
| halt_in | input | 1 | Core is halted |
| wake | output | 1 | Halt release |
| disp_start | output | 1 | Dispatch begins; core clears its master enable |
| disp_busy | output | 1 | Dispatch window active |
| vec_load | output | 1 | Load the vector into the program counter |
| vec_addr | output | 8 | Vector address |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a software write to the flag register and an incoming request. The bench drives both in one cycle and checks that the written value wins.

The second pair is the flag clear at the end of the window and earlier software activity on the same bit. The bench clears the serviced bit by hand in the second window cycle. It then checks that the flip leaves that bit set while the other bits are unchanged.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_IRQ  = 5,
  parameter int VEC_BASE = 8'h40,
  parameter int SEQ_LEN  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         flag_rdata,
  output logic [7:0]         en_rdata,
  input  logic               ime,
  input  logic               halt_in,
  output logic               wake,
  output logic               disp_start,
  output logic               disp_busy,
  output logic               vec_load,
  output logic [7:0]         vec_addr
);
  localparam int IW = $clog2(NUM_IRQ);
  localparam int CW = $clog2(SEQ_LEN + 1);

  logic [NUM_IRQ-1:0] flag_q, en_q, pend, flag_nx;
  logic [IW-1:0]      win_idx, sel_idx;
  logic [CW-1:0]      cnt_q;
  logic               flag_wr;

  assign pend       = flag_q & en_q;
  assign flag_wr    = reg_we && !reg_sel;
  assign flag_rdata = {{(8-NUM_IRQ){1'b1}}, flag_q};
  assign en_rdata   = {{(8-NUM_IRQ){1'b0}}, en_q};
  assign wake       = halt_in && (|pend);
  assign disp_start = ime && !disp_busy && (|pend);
  assign disp_busy  = cnt_q != '0;
  assign vec_load   = cnt_q == CW'(SEQ_LEN);
  assign vec_addr   = 8'(VEC_BASE) + 8'({win_idx, 3'b000});

  always_comb begin
    sel_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (pend[i]) sel_idx = IW'(i);
  end

  always_comb begin
    flag_nx = flag_wr ? reg_wdata[NUM_IRQ-1:0] : (flag_q | irq_req);
    if (vec_load && !flag_wr)
      flag_nx = flag_nx ^ (NUM_IRQ'(1) << win_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= '0;
      en_q    <= '0;
      cnt_q   <= '0;
      win_idx <= '0;
    end else begin
      flag_q <= flag_nx;
      if (reg_we && reg_sel) en_q <= reg_wdata[NUM_IRQ-1:0];
      if (disp_start) begin
        cnt_q   <= CW'(1);
        win_idx <= sel_idx;
      end else if (vec_load) begin
        cnt_q <= '0;
      end else if (disp_busy) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assert_req_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr && !vec_load) |=> ((flag_q & $past(irq_req)) == $past(irq_req)));
  assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (vec_addr[2:0] == 3'b000 && vec_addr >= 8'(VEC_BASE)
                  && vec_addr < 8'(VEC_BASE + 8*NUM_IRQ)));
  assert_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_load && !flag_wr) |=>
      (flag_q[$past(win_idx)] != ($past(flag_q[win_idx]) | $past(irq_req[win_idx]))));
  assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start |-> (ime && (|(en_q & flag_q))));
  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start |=> (disp_busy && !vec_load));
  assert_window_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |=> !disp_busy);
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_busy |-> !disp_start);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  logic clk = 0, rst_n = 0;
  logic [4:0] irq_req = '0;
  logic reg_we = 0, reg_sel = 0, ime = 0, halt_in = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] flag_rdata, en_rdata, vec_addr;
  logic wake, disp_start, disp_busy, vec_load;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u0 (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .flag_rdata(flag_rdata), .en_rdata(en_rdata),
    .ime(ime), .halt_in(halt_in), .wake(wake), .disp_start(disp_start),
    .disp_busy(disp_busy), .vec_load(vec_load), .vec_addr(vec_addr));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d; tick(); reg_we = 0;
  endtask

  task automatic t_reset();
    chk("R8 flag reset", 16'(flag_rdata), 16'h00E0);
    chk("R8 enable reset", 16'(en_rdata), 16'h0000);
    chk("R5 no start at reset", 16'(disp_start), 16'h0);
  endtask

  task automatic t_request();
    irq_req = 5'b00100; tick(); irq_req = '0;
    chk("R1 set bit2", 16'(flag_rdata), 16'h00E4);
    irq_req = 5'b00001; tick(); irq_req = '0;
    chk("R1 or bit0 keeps bit2", 16'(flag_rdata), 16'h00E5);
    wr(1, 8'hFF);
    chk("R8 enable upper bits", 16'(en_rdata), 16'h001F);
    wr(1, 8'h00);
  endtask

  task automatic t_write_wins();
    irq_req = 5'b01000; wr(0, 8'h02); irq_req = '0;
    chk("R9 write beats request", 16'(flag_rdata), 16'h00E2);
    wr(0, 8'h00);
  endtask

  task automatic t_wake();
    halt_in = 1; ime = 0;
    wr(0, 8'h04); #1;
    chk("R4 no wake when disabled", 16'(wake), 16'h0);
    wr(1, 8'h04); #1;
    chk("R4 wake with ime off", 16'(wake), 16'h1);
    chk("R5 no start with ime off", 16'(disp_start), 16'h0);
    halt_in = 0; #1;
    chk("R4 no wake when running", 16'(wake), 16'h0);
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic run_window(string tag, logic [7:0] exp_vec, logic clr_mid);
    ime = 1; #1;
    chk({tag, " R5 start"}, 16'(disp_start), 16'h1);
    tick(); ime = 1;
    for (int i = 1; i <= 5; i++) begin
      #0.5;
      chk({tag, " R6 busy"}, 16'(disp_busy), 16'h1);
      chk({tag, " R10 no restart"}, 16'(disp_start), 16'h0);
      chk({tag, " R6 load timing"}, 16'(vec_load), 16'(i == 5));
      if (i == 5) chk({tag, " R2 vector"}, 16'(vec_addr), 16'(exp_vec));
      if (i == 2 && clr_mid) begin reg_we = 1; reg_sel = 0; reg_wdata = 8'h00; end
      tick(); reg_we = 0;
    end
    ime = 0; #0.5;
    chk({tag, " R6 window closed"}, 16'(disp_busy), 16'h0);
  endtask

  task automatic t_dispatch();
    wr(1, 8'h1F);
    wr(0, 8'h0A);
    run_window("idx1", 8'h48, 0);
    chk("R3 R7 bit1 cleared bit3 kept", 16'(flag_rdata), 16'h00E8);
    run_window("idx3", 8'h58, 0);
    chk("R3 bit3 cleared", 16'(flag_rdata), 16'h00E0);
    wr(0, 8'h10);
    run_window("idx4", 8'h60, 0);
    chk("R3 bit4 cleared", 16'(flag_rdata), 16'h00E0);
  endtask

  task automatic t_toggle();
    wr(0, 8'h01);
    run_window("idx0", 8'h40, 1);
    chk("R3 flip sets bit cleared by software", 16'(flag_rdata), 16'h00E1);
    wr(0, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rst_n = 1; #0.5;
        t_reset();
        t_request();
        t_write_wins();
        t_wake();
        t_dispatch();
        t_toggle();
        done = 1;
      end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule